// File: doc/BRIEF.md
# Repeated-Primitive Expansion Filter

This block sits on the receive side of a serial storage link, directly after the layer that recovers 32-bit dwords and marks which of them are control characters (primitives). A transmitter may shorten a long run of identical primitives by sending a continue primitive and then arbitrary filler dwords. The filter undoes that shortening. It remembers the last real primitive and keeps a repeat-mode flag. On every valid cycle it produces the dword the link layer would have seen with no suppression: fillers that arrive during repeat mode are replaced by the remembered primitive.

The filter also gives the local transmitter a hook. When a hold primitive arrives while repeat mode is active, the filter raises a one-cycle pulse. The transmitter uses that pulse to clear its own history of recently sent primitives. The output stage is registered. Each result appears one clock after its input, together with a valid flag.

Top module: `cont_expander`

## Requirements
- R1: Reset (active-low `rstN`) clears `outValid` and `histClear` and empties repeat mode. It loads the stored primitive with the SYNC code 32'hB5B5957C, so a filler that follows a continue received right after reset is output as SYNC.
- R2: The filter has a latency of exactly one clock. `outValid` equals `inValid` of the previous cycle.
- R3: A valid primitive (`inIsPrim`=1) other than continue (32'h9999AA7C) passes to the output unchanged with `outIsPrim`=1. It becomes the stored primitive and ends repeat mode.
- R4: A valid continue primitive enters repeat mode. Its own output slot carries the stored primitive with `outIsPrim`=1, and the stored primitive keeps its value.
- R5: In repeat mode, a valid non-primitive dword is output as the stored primitive with `outIsPrim`=1. This holds even when its value equals a primitive code.
- R6: Outside repeat mode, a valid non-primitive dword passes through unchanged with `outIsPrim`=0.
- R7: A valid hold primitive (32'hD5D5AA7C) received in repeat mode raises `histClear` for one cycle, in the same cycle as its output. A hold received outside repeat mode does not raise it.
- R8: A cycle with `inValid`=0 changes neither the stored primitive nor repeat mode. The next cycle shows `outValid`=0, `histClear`=0 and an unchanged `outData`.
- R9: A continue received while already in repeat mode keeps repeat mode and still outputs the stored primitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input dword is present this cycle |
| inData | input | 32 | Received dword |
| inIsPrim | input | 1 | Received dword is a control primitive |
| outValid | output | 1 | Output dword is present |
| outData | output | 32 | Effective dword after expansion |
| outIsPrim | output | 1 | Effective dword is a primitive |
| histClear | output | 1 | Pulse: clear the local transmit primitive history |

## Verification
The embedded properties are checked on every clock. They cover the one-cycle valid lag, substitution of fillers during repeat mode, pass-through outside it, the stored primitive staying unchanged across a continue or an idle cycle, and the rule that a history-clear pulse always comes with a hold on the output. Some behaviours need whole input histories: a hold that arrives after a continue and several fillers, the SYNC default showing up after reset, and a filler whose value imitates a primitive code. The bench shows these by sweeping every three-symbol sequence of fillers, primitives and idle cycles against its own model.

// File: rtl/cont_expander_pkg.sv
package cont_expander_pkg;
  localparam int unsigned DW = 32;
  localparam logic [DW-1:0] PRIM_SYNC = 32'hB5B5_957C;
  localparam logic [DW-1:0] PRIM_CONT = 32'h9999_AA7C;
  localparam logic [DW-1:0] PRIM_HOLD = 32'hD5D5_AA7C;

  typedef struct packed {
    logic enterRep;
    logic loadPrim;
    logic substitute;
    logic histClr;
  } ctrlStrb_t;
endpackage

// File: rtl/cont_expander_ctrl.sv
module cont_expander_ctrl
  import cont_expander_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter logic [DATA_W-1:0] CONT_CODE = PRIM_CONT,
  parameter logic [DATA_W-1:0] HOLD_CODE = PRIM_HOLD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inIsPrim,
  input  logic              repMode,
  output ctrlStrb_t         strb
);
  logic primValid;
  logic isCont;
  logic isHold;

  always_comb begin
    primValid = inValid && inIsPrim;
    isCont    = primValid && (inData == CONT_CODE);
    isHold    = primValid && (inData == HOLD_CODE);
    strb.enterRep   = isCont;
    strb.loadPrim   = primValid && !isCont;
    strb.substitute = isCont || (inValid && !inIsPrim && repMode);
    strb.histClr    = isHold && repMode;
  end

  // R3 / R4: a primitive either enters repeat or loads, never both
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enterRep, strb.loadPrim}));

  // R8: no strobe fires on an idle cycle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (strb == '0));
endmodule

// File: rtl/cont_expander_dp.sv
module cont_expander_dp
  import cont_expander_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter logic [DATA_W-1:0] SYNC_CODE = PRIM_SYNC,
  parameter logic [DATA_W-1:0] HOLD_CODE = PRIM_HOLD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inIsPrim,
  input  ctrlStrb_t         strb,
  output logic              repMode,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outIsPrim,
  output logic              histClear
);
  logic [DATA_W-1:0] lastPrim;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      repMode  <= 1'b0;
      lastPrim <= SYNC_CODE;
    end else if (strb.enterRep) begin
      repMode  <= 1'b1;
    end else if (strb.loadPrim) begin
      repMode  <= 1'b0;
      lastPrim <= inData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outIsPrim <= 1'b0;
      histClear <= 1'b0;
    end else begin
      outValid  <= inValid;
      histClear <= strb.histClr;
      if (inValid) begin
        outData   <= strb.substitute ? lastPrim : inData;
        outIsPrim <= strb.substitute || inIsPrim;
      end
    end
  end

  p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_invalid_lag_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_cont_keeps_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.enterRep |=> (repMode && $stable(lastPrim)));
  p_subst_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inIsPrim && repMode) |=> (outData == $past(lastPrim) && outIsPrim));
  p_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inIsPrim && !repMode) |=> (outData == $past(inData) && !outIsPrim));
  p_hist_with_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    histClear |-> (outValid && outIsPrim && outData == HOLD_CODE));
  p_idle_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(lastPrim) && $stable(repMode) && $stable(outData) && !histClear));
endmodule

// File: rtl/cont_expander.sv
module cont_expander
  import cont_expander_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter logic [DATA_W-1:0] SYNC_CODE = PRIM_SYNC,
  parameter logic [DATA_W-1:0] CONT_CODE = PRIM_CONT,
  parameter logic [DATA_W-1:0] HOLD_CODE = PRIM_HOLD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inIsPrim,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outIsPrim,
  output logic              histClear
);
  ctrlStrb_t strb;
  logic      repMode;

  cont_expander_ctrl #(
    .DATA_W(DATA_W), .CONT_CODE(CONT_CODE), .HOLD_CODE(HOLD_CODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inIsPrim(inIsPrim), .repMode(repMode), .strb(strb)
  );

  cont_expander_dp #(
    .DATA_W(DATA_W), .SYNC_CODE(SYNC_CODE), .HOLD_CODE(HOLD_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inIsPrim(inIsPrim), .strb(strb), .repMode(repMode),
    .outValid(outValid), .outData(outData), .outIsPrim(outIsPrim),
    .histClear(histClear)
  );
endmodule

// File: tb/cont_expander_bench.sv
`timescale 1ns/1ps
module cont_expander_bench;
  localparam logic [31:0] SYNC = 32'hB5B5_957C;
  localparam logic [31:0] CONT = 32'h9999_AA7C;
  localparam logic [31:0] HOLD = 32'hD5D5_AA7C;
  localparam logic [31:0] XRDY = 32'h5757_B57C;
  localparam logic [31:0] FILL = 32'h1234_5678;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inIsPrim = 1'b0;
  logic        outValid;
  logic [31:0] outData;
  logic        outIsPrim;
  logic        histClear;

  int checks = 0;
  int errors = 0;

  logic        mRep;
  logic [31:0] mLast;
  logic [31:0] mOut;
  logic        mOutPrim;

  always #2.5 clk = ~clk;

  cont_expander u_cont_expander (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inIsPrim(inIsPrim), .outValid(outValid), .outData(outData),
    .outIsPrim(outIsPrim), .histClear(histClear)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; inData = '0; inIsPrim = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    rstN = 1'b1;
    mRep = 1'b0; mLast = SYNC; mOut = '0; mOutPrim = 1'b0;
    check("R1", "outValid after reset", {31'b0, outValid}, 32'd0);
    check("R1", "histClear after reset", {31'b0, histClear}, 32'd0);
  endtask

  // sym: 0 filler, 1 filler carrying CONT value, 2 SYNC, 3 CONT, 4 HOLD, 5 other prim, 6 idle
  task automatic step(input int sym, input string forceReq);
    logic v, p, expHist, subst;
    logic [31:0] d;
    string req;
    v = (sym != 6);
    case (sym)
      0: begin d = FILL;  p = 1'b0; end
      1: begin d = CONT;  p = 1'b0; end
      2: begin d = SYNC;  p = 1'b1; end
      3: begin d = CONT;  p = 1'b1; end
      4: begin d = HOLD;  p = 1'b1; end
      5: begin d = XRDY;  p = 1'b1; end
      default: begin d = 32'hDEAD_0000; p = 1'b1; end
    endcase
    @(negedge clk);
    inValid = v; inData = d; inIsPrim = p;
    expHist = 1'b0;
    if (!v) req = "R8";
    else if (p && d == CONT) req = mRep ? "R9" : "R4";
    else if (p) req = "R3";
    else req = mRep ? "R5" : "R6";
    if (forceReq != "") req = forceReq;
    if (v) begin
      subst = (p && d == CONT) || (!p && mRep);
      mOut = subst ? mLast : d;
      mOutPrim = subst || p;
      expHist = p && d == HOLD && mRep;
      if (p && d == CONT) mRep = 1'b1;
      else if (p) begin mRep = 1'b0; mLast = d; end
    end
    @(posedge clk); #1;
    check("R2", "outValid", {31'b0, outValid}, {31'b0, v});
    check(req, "outData", outData, mOut);
    if (v) check(req, "outIsPrim", {31'b0, outIsPrim}, {31'b0, mOutPrim});
    check("R7", "histClear", {31'b0, histClear}, {31'b0, expHist});
    @(negedge clk);
    inValid = 1'b0;
    check("R8", "histClear one-cycle", {31'b0, histClear}, {31'b0, expHist});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R1: filler after a continue right after reset yields SYNC
    step(3, "R4");
    step(0, "R1");
    check("R1", "default stored primitive", outData, SYNC);
    // R7: hold outside repeat gives no pulse
    step(4, "R7");
    doReset();
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        for (int c = 0; c < 7; c++) begin
          step(a, "");
          step(b, "");
          step(c, "");
        end
    // mid-run reset restores default
    step(5, "");
    step(3, "");
    doReset();
    step(3, "R4");
    step(1, "R1");
    check("R1", "SYNC after second reset", outData, SYNC);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule